// File: doc/BRIEF.md
# Histogram Marker and Peak Tracker

This block sits beside an accumulator memory and watches the stream of address/word pairs produced while that memory is swept during a readout. It holds seven programmable markers and one peak record. Each marker keeps a 9-bit grey level and a 24-bit count. A global direction input sets what the stream fills in. In grey-to-count direction, every marker picks up the count found at its own grey level. In count-to-grey direction, every marker records the first grey level whose count reaches or passes its programmed count. The peak record keeps the largest count of the sweep and the grey level where it was found.

Software reaches all of these values through a small register window. It uses a 6-bit register address, 9-bit write data, an active-low write strobe and a select input that routes the access to this window. Each 24-bit count is exposed as three 9-bit slices. The sequencer that produces the sweep marks the first pair of each sweep with a start pulse. It also flags whether the pair comes from an accumulator access; pairs from lookup-table-only operations carry the flag low.

Top module: `histo_marker_tracker`

## Requirements
- R1: After a synchronous active-low reset, every peak and marker register reads back 0.
- R2: With the select high, marker k (0..6) is at register addresses 32+4k to 35+4k: grey level, then count bits 8:0, bits 17:9, and bits 23:18 placed in read bits 5:0 with bits 8:6 reading 0. These locations are written on a clock edge where the write strobe is low, and they read back on the combinational read data.
- R3: Addresses 0..3 return the peak grey level, then count bits 8:0, 17:9 and 23:18 (right-justified), in that order. Writes to them have no effect.
- R4: With the select low, writes have no effect and the read data is 0. With the select high, addresses outside 0..3 and 32..59 read 0 and ignore writes.
- R5: With the direction input at 1, a marker's count takes the stream word whose address equals that marker's grey level. Its grey level is left as it is.
- R6: With the direction input at 0, a marker's grey level takes the address of the first pair in the sweep whose word is greater than or equal to its count. Later pairs in that sweep do not change it. If no pair qualifies, the grey level stays as it was. The count is left as it is.
- R7: The start pulse clears the peak record, and the pair that comes with the pulse is the first one compared. The peak then holds the largest word of the sweep. On a tie, the earlier address is kept.
- R8: When the sweep carries a running sum, as in equalize mode, the peak count equals the total and the peak grey level equals the highest address whose own bin is nonzero.
- R9: Markers and peak change only on pairs whose valid input and accumulator flag are both high. A sweep with the accumulator flag low leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_start | input | 1 | Marks the first pair of a sweep |
| s_valid | input | 1 | Stream pair valid |
| s_acc | input | 1 | Pair comes from an accumulator access |
| s_addr | input | 9 | Stream address (grey level) |
| s_word | input | 24 | Stream word (count) |
| grey_to_count | input | 1 | Marker direction: 1 grey-to-count, 0 count-to-grey |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 9 | Register write data |
| reg_wr_n | input | 1 | Active-low write strobe |
| reg_msel | input | 1 | Routes the access to this register window |
| reg_rdata | output | 9 | Register read data |

## Verification
The bench goes after count-to-grey histograms that cross a threshold early and then climb higher later; a design that keeps overwriting would report a late grey level. It builds sweeps with repeated maximum words; a design that compares with greater-or-equal would report the last tied address instead of the first. Running-sum sweeps with empty top bins catch a peak that moves onto trailing equal sums. Counts above 2^18 exercise the top slice, and lookup-only sweeps and writes to read-only or unselected addresses must leave every readback unchanged.

// File: rtl/hmt_pkg.sv
// Package: shared widths of the marker/peak tracker.
package hmt_pkg;
    localparam int GREY_W   = 9;   // grey level and register slice width
    localparam int COUNT_W  = 24;  // accumulator word width
    localparam int NUM_MARK = 7;   // number of markers
    localparam int RADDR_W  = 6;   // register address width
endpackage

// File: rtl/hmt_marker_cell.sv
// One marker: grey level plus count, filled from the sweep in one of two
// directions, and writable through per-field write enables.
// Assumes a sweep is framed by sweep_start on its first pair.
module hmt_marker_cell #(
    parameter int GW = hmt_pkg::GREY_W,
    parameter int CW = hmt_pkg::COUNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sweep_start,
    input  logic          upd,
    input  logic          dir_g2c,
    input  logic [GW-1:0] s_addr,
    input  logic [CW-1:0] s_word,
    input  logic          wr_grey,
    input  logic [2:0]    wr_slice,
    input  logic [GW-1:0] wdata,
    output logic [GW-1:0] grey_o,
    output logic [CW-1:0] count_o
);
    localparam int TOP_W = CW - 2*GW;

    logic hit;   // count-to-grey crossing already latched in this sweep
    logic armed;

    assign armed = sweep_start || !hit;

    // Stream capture, then software writes which take precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grey_o  <= '0;
            count_o <= '0;
            hit     <= 1'b0;
        end else begin
            if (sweep_start) hit <= 1'b0;
            if (upd) begin
                if (dir_g2c) begin
                    if (s_addr == grey_o) count_o <= s_word;
                end else if (armed && (s_word >= count_o)) begin
                    grey_o <= s_addr;
                    hit    <= 1'b1;
                end
            end
            if (wr_grey)     grey_o                   <= wdata;
            if (wr_slice[0]) count_o[GW-1:0]          <= wdata;
            if (wr_slice[1]) count_o[GW +: GW]        <= wdata;
            if (wr_slice[2]) count_o[2*GW +: TOP_W]   <= wdata[TOP_W-1:0];
        end
    end

    // R6
    first_cross_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !sweep_start && !wr_grey && !dir_g2c) |=> $stable(grey_o));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !wr_grey && (wr_slice == 3'b000)) |=> ($stable(grey_o) && $stable(count_o)));
    // R5
    g2c_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && dir_g2c && (s_addr == grey_o) && (wr_slice == 3'b000)) |=> (count_o == $past(s_word)));
endmodule

// File: rtl/hmt_peak_tracker.sv
// Peak record: largest word of the sweep and its address. Cleared by the
// start pulse; strict comparison keeps the earliest address on a tie.
module hmt_peak_tracker #(
    parameter int GW = hmt_pkg::GREY_W,
    parameter int CW = hmt_pkg::COUNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sweep_start,
    input  logic          upd,
    input  logic [GW-1:0] s_addr,
    input  logic [CW-1:0] s_word,
    output logic [GW-1:0] peak_grey,
    output logic [CW-1:0] peak_count
);
    logic [CW-1:0] base;

    // Comparison base: the start pair competes against an empty record.
    always_comb base = sweep_start ? '0 : peak_count;

    // Clear on sweep start, take a strictly larger word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak_grey  <= '0;
            peak_count <= '0;
        end else begin
            if (sweep_start) begin
                peak_grey  <= '0;
                peak_count <= '0;
            end
            if (upd && (s_word > base)) begin
                peak_grey  <= s_addr;
                peak_count <= s_word;
            end
        end
    end

    // R7
    peak_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sweep_start |=> (peak_count >= $past(peak_count)));
    // R7
    peak_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_start && !upd) |=> (peak_count == '0 && peak_grey == '0));
    // R7
    peak_tie_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !sweep_start && (s_word <= peak_count)) |=> $stable(peak_grey));
endmodule

// File: rtl/hmt_reg_port.sv
// Register window: decodes address/strobe/select into per-field write
// enables and muxes peak and marker slices onto the read data.
// Assumes NUM_MARK <= 8 so markers fit the upper half of the address space.
module hmt_reg_port #(
    parameter int GW = hmt_pkg::GREY_W,
    parameter int CW = hmt_pkg::COUNT_W,
    parameter int NM = hmt_pkg::NUM_MARK,
    parameter int AW = hmt_pkg::RADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         reg_addr,
    input  logic                  reg_wr_n,
    input  logic                  reg_msel,
    input  logic [GW-1:0]         peak_grey,
    input  logic [CW-1:0]         peak_count,
    input  logic [NM-1:0][GW-1:0] m_grey,
    input  logic [NM-1:0][CW-1:0] m_count,
    output logic [NM-1:0]         wr_grey,
    output logic [NM-1:0][2:0]    wr_slice,
    output logic [GW-1:0]         rdata
);
    localparam int TOP_W = CW - 2*GW;

    logic          in_peak;
    logic          in_mark;
    logic [2:0]    idx;
    logic [1:0]    field;
    logic          wr_act;

    assign idx     = reg_addr[4:2];
    assign field   = reg_addr[1:0];
    assign in_peak = reg_msel && (reg_addr[AW-1:2] == '0);
    assign in_mark = reg_msel && reg_addr[AW-1] && (int'(idx) < NM);
    assign wr_act  = in_mark && !reg_wr_n;

    // Per-marker field write enables.
    for (genvar k = 0; k < NM; k++) begin : g_wen
        assign wr_grey[k] = wr_act && (idx == 3'(k)) && (field == 2'd0);
        for (genvar j = 0; j < 3; j++) begin : g_sl
            assign wr_slice[k][j] = wr_act && (idx == 3'(k)) && (field == 2'(j+1));
        end
    end

    // Pick one 9-bit field of a grey/count pair.
    function automatic logic [GW-1:0] pick(input logic [1:0] f,
                                           input logic [GW-1:0] g,
                                           input logic [CW-1:0] c);
        case (f)
            2'd0:    pick = g;
            2'd1:    pick = c[GW-1:0];
            2'd2:    pick = c[GW +: GW];
            default: pick = GW'(c[2*GW +: TOP_W]);
        endcase
    endfunction

    // Read mux; unmapped or unselected reads give zero.
    always_comb begin
        rdata = '0;
        if (in_peak)      rdata = pick(field, peak_grey, peak_count);
        else if (in_mark) rdata = pick(field, m_grey[idx], m_count[idx]);
    end

    // R2
    one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_grey, wr_slice}));
    // R4
    no_strobe_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_n || !reg_msel) |-> ((wr_grey == '0) && (wr_slice == '0)));
endmodule

// File: rtl/histo_marker_tracker.sv
// Top: seven markers and one peak record fed from an accumulator sweep,
// exposed through a 6-bit register window. Stream pairs count only when
// both valid and the accumulator flag are high.
module histo_marker_tracker #(
    parameter int GW = hmt_pkg::GREY_W,
    parameter int CW = hmt_pkg::COUNT_W,
    parameter int NM = hmt_pkg::NUM_MARK,
    parameter int AW = hmt_pkg::RADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_start,
    input  logic          s_valid,
    input  logic          s_acc,
    input  logic [GW-1:0] s_addr,
    input  logic [CW-1:0] s_word,
    input  logic          grey_to_count,
    input  logic [AW-1:0] reg_addr,
    input  logic [GW-1:0] reg_wdata,
    input  logic          reg_wr_n,
    input  logic          reg_msel,
    output logic [GW-1:0] reg_rdata
);
    logic                  upd;
    logic                  sweep_start;
    logic [GW-1:0]         peak_grey;
    logic [CW-1:0]         peak_count;
    logic [NM-1:0][GW-1:0] m_grey;
    logic [NM-1:0][CW-1:0] m_count;
    logic [NM-1:0]         wr_grey;
    logic [NM-1:0][2:0]    wr_slice;

    assign upd         = s_valid && s_acc;
    assign sweep_start = sw_start && s_acc;

    hmt_peak_tracker #(.GW(GW), .CW(CW)) u_peak (
        .clk(clk), .rst_n(rst_n), .sweep_start(sweep_start), .upd(upd),
        .s_addr(s_addr), .s_word(s_word),
        .peak_grey(peak_grey), .peak_count(peak_count));

    for (genvar k = 0; k < NM; k++) begin : g_mark
        hmt_marker_cell #(.GW(GW), .CW(CW)) u_cell (
            .clk(clk), .rst_n(rst_n), .sweep_start(sweep_start), .upd(upd),
            .dir_g2c(grey_to_count), .s_addr(s_addr), .s_word(s_word),
            .wr_grey(wr_grey[k]), .wr_slice(wr_slice[k]), .wdata(reg_wdata),
            .grey_o(m_grey[k]), .count_o(m_count[k]));
    end

    hmt_reg_port #(.GW(GW), .CW(CW), .NM(NM), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_n(reg_wr_n),
        .reg_msel(reg_msel), .peak_grey(peak_grey), .peak_count(peak_count),
        .m_grey(m_grey), .m_count(m_count), .wr_grey(wr_grey),
        .wr_slice(wr_slice), .rdata(reg_rdata));

    // R9
    lut_only_peak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(peak_count) && $stable(peak_grey)));
endmodule

// File: tb/histo_marker_tracker_tb.sv
// Bench: random histograms with a fixed seed plus directed corner sweeps,
// checked through the register window against a bench model.
module histo_marker_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_start = 1'b0, s_valid = 1'b0, s_acc = 1'b0;
    logic [8:0]  s_addr = '0;
    logic [23:0] s_word = '0;
    logic        grey_to_count = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [8:0]  reg_wdata = '0;
    logic        reg_wr_n = 1'b1, reg_msel = 1'b0;
    logic [8:0]  reg_rdata;

    int errors = 0, checks = 0;
    bit done = 0;

    int unsigned hist [512];
    int unsigned e_grey [7];
    int unsigned e_cnt  [7];
    int unsigned e_pg, e_pc;

    always #5 clk = ~clk;

    histo_marker_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .s_valid(s_valid),
        .s_acc(s_acc), .s_addr(s_addr), .s_word(s_word),
        .grey_to_count(grey_to_count), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wr_n(reg_wr_n), .reg_msel(reg_msel),
        .reg_rdata(reg_rdata));

    task automatic chk(input string req, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int unsigned field(input int unsigned g, input int unsigned c, input int f);
        case (f)
            0: return g;
            1: return c & 32'h1FF;
            2: return (c >> 9) & 32'h1FF;
            default: return (c >> 18) & 32'h3F;
        endcase
    endfunction

    task automatic rd(input int a, output int unsigned d);
        reg_msel = 1'b1; reg_addr = 6'(a); #1;
        d = reg_rdata;
    endtask

    task automatic wr(input int a, input int unsigned d, input bit sel);
        reg_msel = sel; reg_addr = 6'(a); reg_wdata = 9'(d); reg_wr_n = 1'b0;
        @(negedge clk);
        reg_wr_n = 1'b1; reg_msel = 1'b0;
    endtask

    task automatic program_marker(input int k, input int unsigned g, input int unsigned c);
        for (int f = 0; f < 4; f++) wr(32 + 4*k + f, field(g, c, f), 1'b1);
        e_grey[k] = g; e_cnt[k] = c;
    endtask

    task automatic check_all(input string req);
        int unsigned d;
        for (int f = 0; f < 4; f++) begin
            rd(f, d); chk({req, " peak"}, d, field(e_pg, e_pc, f));
        end
        for (int k = 0; k < 7; k++)
            for (int f = 0; f < 4; f++) begin
                rd(32 + 4*k + f, d); chk({req, " marker"}, d, field(e_grey[k], e_cnt[k], f));
            end
    endtask

    // Bench model of one full ascending sweep.
    function automatic void model_sweep(input bit dir, input bit acc);
        if (!acc) return;
        e_pg = 0; e_pc = 0;
        for (int a = 0; a < 512; a++)
            if (hist[a] > e_pc) begin e_pc = hist[a]; e_pg = a; end
        for (int k = 0; k < 7; k++) begin
            if (dir) e_cnt[k] = hist[e_grey[k]];
            else begin
                for (int a = 0; a < 512; a++)
                    if (hist[a] >= e_cnt[k]) begin e_grey[k] = a; break; end
            end
        end
    endfunction

    task automatic run_sweep(input bit dir, input bit acc);
        grey_to_count = dir;
        for (int a = 0; a < 512; a++) begin
            sw_start = (a == 0); s_valid = 1'b1; s_acc = acc;
            s_addr = 9'(a); s_word = 24'(hist[a]);
            @(negedge clk);
        end
        sw_start = 1'b0; s_valid = 1'b0; s_acc = 1'b0;
        model_sweep(dir, acc);
    endtask

    task automatic rand_hist();
        for (int a = 0; a < 512; a++)
            hist[a] = ($urandom % 5 == 0) ? ($urandom & 32'hFFFFFE) : ($urandom % 64);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned d, hi;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        e_pg = 0; e_pc = 0;
        for (int k = 0; k < 7; k++) begin e_grey[k] = 0; e_cnt[k] = 0; end
        check_all("R1");

        // R2: program and read back, including top slice.
        for (int k = 0; k < 7; k++) program_marker(k, $urandom % 512, $urandom & 32'hFFFFFF);
        check_all("R2");

        // R3: peak addresses are read-only.
        for (int a = 0; a < 4; a++) wr(a, 9'h1AB, 1'b1);
        check_all("R3");
        // R4: select low ignores writes and reads 0; unmapped addresses.
        wr(32, 9'h155, 1'b0);
        reg_msel = 1'b0; reg_addr = 6'd32; #1; chk("R4 sel low read", reg_rdata, 0);
        wr(60, 9'h1FF, 1'b1); rd(60, d); chk("R4 unmapped", d, 0);
        wr(10, 9'h1FF, 1'b1); rd(10, d); chk("R4 unmapped low", d, 0);
        check_all("R4");

        // R5 / R7: grey-to-count sweeps on random data.
        for (int r = 0; r < 3; r++) begin
            rand_hist();
            for (int k = 0; k < 7; k++) program_marker(k, $urandom % 512, e_cnt[k]);
            run_sweep(1'b1, 1'b1);
            check_all("R5 R7");
        end

        // R6: count-to-grey, thresholds reachable early, one unreachable.
        for (int r = 0; r < 3; r++) begin
            rand_hist();
            for (int k = 0; k < 6; k++) program_marker(k, 9'h100 + k, hist[$urandom % 512]);
            program_marker(6, 9'h0AA, 32'hFFFFFF);
            run_sweep(1'b0, 1'b1);
            check_all("R6");
        end
        // R6: directed early crossing followed by larger words.
        for (int a = 0; a < 512; a++) hist[a] = 0;
        hist[20] = 100; hist[300] = 5000; hist[400] = 100;
        for (int k = 0; k < 7; k++) program_marker(k, 9'h1F0, 50);
        run_sweep(1'b0, 1'b1);
        rd(32, d); chk("R6 first crossing", d, 20);
        check_all("R6");

        // R7: tie for the maximum keeps the earliest address.
        for (int a = 0; a < 512; a++) hist[a] = a % 7;
        hist[37] = 32'h3C0001; hist[200] = 32'h3C0001; hist[480] = 32'h3C0001;
        run_sweep(1'b1, 1'b1);
        rd(0, d); chk("R7 tie grey", d, 37);
        check_all("R7");

        // R8: running-sum sweep with empty top bins.
        begin
            int unsigned sum = 0;
            hi = 0;
            for (int a = 0; a < 512; a++) begin
                int unsigned b = (a < 350) ? ($urandom % 3000) : 0;
                if (b != 0) hi = a;
                sum += b; hist[a] = sum;
            end
            run_sweep(1'b1, 1'b1);
            rd(0, d); chk("R8 peak grey", d, hi);
            rd(1, d); chk("R8 total lo", d, sum & 32'h1FF);
            rd(3, d); chk("R8 total hi", d, (sum >> 18) & 32'h3F);
        end

        // R9: lookup-only sweep changes nothing.
        rand_hist();
        run_sweep(1'b1, 1'b0);
        check_all("R9");
        run_sweep(1'b0, 1'b0);
        check_all("R9");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule